// File: doc/BRIEF.md
# Dithered Fine-Tune Phase Accumulator

This block drives a phase-accumulator oscillator whose tuning word is finer than the accumulator itself. A wide frequency request is split into two parts. The upper ACC_W bits are the base tuning word. The lower FRAC_W bits are a fraction that sets a pulse-width pattern.

That pattern alternates the word actually added to the accumulator between base and base plus one. Over one pattern period of 2^FRAC_W cycles, the word is base plus one for exactly `fraction` cycles. The mean frequency therefore resolves ACC_W+FRAC_W bits, but only when averaged over whole periods. With the defaults this gives 48 plus 16, or 64 bits. The block outputs the word applied in the current cycle, the phase register, the registered carry out of the phase add, and the phase MSB as a square wave.

A small state machine sequences the pattern, with three states:
- PH_LOAD is the single cycle after reset. It applies a zero word, samples the request and moves to PH_HIGH if the fraction is nonzero, otherwise to PH_LOW.
- PH_HIGH applies base plus one. It moves to PH_LOW on the edge at which the next counter value equals the fraction.
- PH_LOW applies base.

From PH_HIGH or PH_LOW, the last cycle of a period (counter all ones) samples a fresh request. The next state is again PH_HIGH or PH_LOW, depending on whether the new fraction is nonzero.

Top module: `nco_dither`

## Requirements
- R1: While reset is low, `tune_o`, `acc_o`, `carry_o` and `square_o` are all zero. The first cycle after reset release applies a zero word.
- R2: The request is split as `freq_req[REQ_W-1:FRAC_W]` = base and `freq_req[FRAC_W-1:0]` = fraction. In period cycle i (0 to 2^FRAC_W-1), `tune_o` is base+1 when i < fraction and base otherwise.
- R3: A fraction of zero applies the base word in every cycle of the period.
- R4: Summed over one full period, the applied words equal base*2^FRAC_W + fraction, modulo 2^ACC_W.
- R5: When base is all ones and the fraction is nonzero, the base-plus-one cycles apply zero, because the increment wraps.
- R6: The request is sampled only on the edge that ends the post-reset cycle and on the edge that ends each period's last cycle. A request change in mid-period does not alter `tune_o` until the next period.
- R7: Every clock, `acc_o` advances by the word applied in the previous cycle, modulo 2^ACC_W.
- R8: `carry_o` is high for one cycle after each add that overflows `acc_o`. `square_o` equals the top bit of `acc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freq_req | input | ACC_W+FRAC_W | Requested frequency word: base in the upper part, fraction in the lower |
| tune_o | output | ACC_W | Tuning word applied in this cycle |
| acc_o | output | ACC_W | Phase accumulator |
| carry_o | output | 1 | Carry out of the previous phase add |
| square_o | output | 1 | Accumulator MSB as a square wave |

## Verification
The bench is built with a narrower fraction field so that complete periods fit in a short run.

It compares every cycle of each period against the expected word. A design whose high-phase comparison is off by one would show one base-plus-one cycle too many or too few, which breaks the period sum. Fractions of zero, one and all ones are all covered. So is an all-ones base, where a design that saturated instead of wrapping would apply the wrong word.

A request change in mid-period exposes a design that loads at once rather than at the boundary. A large base forces accumulator overflows, which catches a carry output that is unregistered or misaligned by a cycle.

// File: rtl/nco_dither_pkg.sv
package nco_dither_pkg;

    // Phase of the dither pattern; selects the applied word.
    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } dither_state_t;

endpackage

// File: rtl/nco_dither_seq.sv
module nco_dither_seq
    import nco_dither_pkg::*;
#(
    parameter int ACC_W  = 48,
    parameter int FRAC_W = 16,
    localparam int REQ_W = ACC_W + FRAC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REQ_W-1:0]    freq_req,
    output dither_state_t       state_o,
    output logic [FRAC_W-1:0]   cnt_o,
    output logic [ACC_W-1:0]    base_o,
    output logic [FRAC_W-1:0]   frac_o
);

    localparam logic [FRAC_W-1:0] CNT_MAX = {FRAC_W{1'b1}};
    localparam logic [FRAC_W-1:0] CNT_ONE = {{(FRAC_W-1){1'b0}}, 1'b1};

    dither_state_t      state_q, state_d;
    logic [FRAC_W-1:0]  cnt_q, cnt_d, cnt_inc;
    logic [ACC_W-1:0]   base_q, base_d;
    logic [FRAC_W-1:0]  frac_q, frac_d;
    logic [ACC_W-1:0]   req_base;
    logic [FRAC_W-1:0]  req_frac;
    logic               period_end;
    logic               take_req;

    assign req_base   = freq_req[REQ_W-1:FRAC_W];
    assign req_frac   = freq_req[FRAC_W-1:0];
    assign cnt_inc    = cnt_q + CNT_ONE;
    assign period_end = (state_q != PH_LOAD) && (cnt_q == CNT_MAX);
    assign take_req   = (state_q == PH_LOAD) || period_end;

    // Next-state and datapath decisions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOAD: state_d = (req_frac != '0) ? PH_HIGH : PH_LOW;
            PH_HIGH: begin
                if (period_end)
                    state_d = (req_frac != '0) ? PH_HIGH : PH_LOW;
                else if (cnt_inc == frac_q)
                    state_d = PH_LOW;
                else
                    state_d = PH_HIGH;
            end
            PH_LOW: begin
                if (period_end)
                    state_d = (req_frac != '0) ? PH_HIGH : PH_LOW;
                else
                    state_d = PH_LOW;
            end
            default: state_d = PH_LOAD;
        endcase

        cnt_d  = (state_q == PH_LOAD) ? '0 : cnt_inc;
        base_d = take_req ? req_base : base_q;
        frac_d = take_req ? req_frac : frac_q;
    end

    // State and setting registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_LOAD;
            cnt_q   <= '0;
            base_q  <= '0;
            frac_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            base_q  <= base_d;
            frac_q  <= frac_d;
        end
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;
    assign base_o  = base_q;
    assign frac_o  = frac_q;

endmodule

// File: rtl/nco_dither_word.sv
module nco_dither_word
    import nco_dither_pkg::*;
#(
    parameter int ACC_W = 48
) (
    input  dither_state_t     state_i,
    input  logic [ACC_W-1:0]  base_i,
    output logic [ACC_W-1:0]  tune_o
);

    localparam logic [ACC_W-1:0] ONE = {{(ACC_W-1){1'b0}}, 1'b1};

    // Output process: word applied by phase.
    always_comb begin
        unique case (state_i)
            PH_HIGH: tune_o = base_i + ONE;
            PH_LOW:  tune_o = base_i;
            PH_LOAD: tune_o = '0;
            default: tune_o = '0;
        endcase
    end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  step_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic              carry_o
);

    logic [ACC_W:0] sum;

    assign sum = {1'b0, acc_o} + {1'b0, step_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o   <= '0;
            carry_o <= 1'b0;
        end else begin
            acc_o   <= sum[ACC_W-1:0];
            carry_o <= sum[ACC_W];
        end
    end

endmodule

// File: rtl/nco_dither.sv
module nco_dither
    import nco_dither_pkg::*;
#(
    parameter int ACC_W  = 48,
    parameter int FRAC_W = 16,
    localparam int REQ_W = ACC_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REQ_W-1:0]  freq_req,
    output logic [ACC_W-1:0]  tune_o,
    output logic [ACC_W-1:0]  acc_o,
    output logic              carry_o,
    output logic              square_o
);

    dither_state_t      st;
    logic [FRAC_W-1:0]  pwm_cnt;
    logic [ACC_W-1:0]   base_q;
    logic [FRAC_W-1:0]  frac_q;

    nco_dither_seq #(
        .ACC_W  (ACC_W),
        .FRAC_W (FRAC_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .freq_req (freq_req),
        .state_o  (st),
        .cnt_o    (pwm_cnt),
        .base_o   (base_q),
        .frac_o   (frac_q)
    );

    nco_dither_word #(
        .ACC_W (ACC_W)
    ) u_word (
        .state_i (st),
        .base_i  (base_q),
        .tune_o  (tune_o)
    );

    nco_phase_acc #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (tune_o),
        .acc_o   (acc_o),
        .carry_o (carry_o)
    );

    assign square_o = acc_o[ACC_W-1];

endmodule

// File: rtl/nco_dither_checker.sv
module nco_dither_checker
    import nco_dither_pkg::*;
#(
    parameter int ACC_W  = 48,
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dither_state_t     state,
    input  logic [FRAC_W-1:0] cnt,
    input  logic [ACC_W-1:0]  base_q,
    input  logic [FRAC_W-1:0] frac_q,
    input  logic [ACC_W-1:0]  tune_o,
    input  logic [ACC_W-1:0]  acc_o,
    input  logic              carry_o,
    input  logic              square_o
);

    localparam logic [FRAC_W-1:0] CNT_MAX = {FRAC_W{1'b1}};

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (acc_o == '0 && !carry_o && tune_o == '0));

    p_phase_vs_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_LOAD) |-> ((state == PH_HIGH) == (cnt < frac_q)));

    p_zero_frac_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_LOAD && frac_q == '0) |-> (tune_o == base_q));

    p_wrap_to_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_HIGH && (&base_q)) |-> (tune_o == '0));

    p_hold_midperiod_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_LOAD && cnt != CNT_MAX) |=> ($stable(base_q) && $stable(frac_q)));

    p_acc_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ({carry_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(tune_o)})));

    p_square_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        square_o == acc_o[ACC_W-1]);

endmodule

bind nco_dither nco_dither_checker #(
    .ACC_W  (ACC_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (st),
    .cnt      (pwm_cnt),
    .base_q   (base_q),
    .frac_q   (frac_q),
    .tune_o   (tune_o),
    .acc_o    (acc_o),
    .carry_o  (carry_o),
    .square_o (square_o)
);

// File: tb/nco_dither_bench.sv
`timescale 1ns/1ps
module nco_dither_bench;

    localparam int ACC_W  = 48;
    localparam int FRAC_W = 8;
    localparam int REQ_W  = ACC_W + FRAC_W;
    localparam int P      = 1 << FRAC_W;
    localparam logic [ACC_W-1:0] ALL1 = {ACC_W{1'b1}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [REQ_W-1:0]  freq_req = '0;
    logic [ACC_W-1:0]  tune_o, acc_o;
    logic              carry_o, square_o;

    int n_tests = 0;
    int n_fail  = 0;
    int carries_seen = 0;
    int sq_toggles = 0;

    logic [ACC_W-1:0] exp_acc = '0;
    logic [ACC_W-1:0] prev_tw = '0;
    logic             exp_carry = 1'b0;
    logic             last_sq = 1'b0;

    always #2.5 clk = ~clk;

    nco_dither #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_nco_dither (
        .clk      (clk),
        .rst_n    (rst_n),
        .freq_req (freq_req),
        .tune_o   (tune_o),
        .acc_o    (acc_o),
        .carry_o  (carry_o),
        .square_o (square_o)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: update the accumulator model, then compare at the negedge.
    task automatic step(input logic [ACC_W-1:0] exp_tw, input string tag);
        logic [ACC_W:0] s;
        @(posedge clk);
        s = {1'b0, exp_acc} + {1'b0, prev_tw};
        exp_acc = s[ACC_W-1:0];
        exp_carry = s[ACC_W];
        prev_tw = exp_tw;
        @(negedge clk);
        check(tune_o == exp_tw, tag, 64'(tune_o), 64'(exp_tw));
        check(acc_o == exp_acc, "R7 accumulator", 64'(acc_o), 64'(exp_acc));
        check(carry_o == exp_carry, "R8 carry", 64'(carry_o), 64'(exp_carry));
        check(square_o == exp_acc[ACC_W-1], "R8 square", 64'(square_o), 64'(exp_acc[ACC_W-1]));
        if (carry_o) carries_seen++;
        if (square_o != last_sq) sq_toggles++;
        last_sq = square_o;
    endtask

    // Runs one full period; the caller must be at the negedge of a load cycle.
    task automatic run_period(input logic [REQ_W-1:0] r, input bit drive,
                              input int swap_at, input logic [REQ_W-1:0] swap_req,
                              input string tag);
        logic [ACC_W-1:0]  b, e, sum;
        logic [FRAC_W-1:0] f;
        int hi;
        b = r[REQ_W-1:FRAC_W];
        f = r[FRAC_W-1:0];
        if (drive) freq_req = r;
        sum = '0;
        hi = 0;
        for (int i = 0; i < P; i++) begin
            if (i == swap_at) freq_req = swap_req;
            e = (i < int'(f)) ? b + 1'b1 : b;
            step(e, tag);
            sum = sum + tune_o;
            if (tune_o != b) hi++;
        end
        check(hi == int'(f), "R2 high-cycle count", 64'(hi), 64'(f));
        check(sum == b * P + f, "R4 period sum", 64'(sum), 64'(b * P + f));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(tune_o == '0 && acc_o == '0, "R1 reset word/acc", 64'(tune_o | acc_o), 64'd0);
        check(!carry_o && !square_o, "R1 reset carry/square", 64'({carry_o, square_o}), 64'd0);
        rst_n = 1'b1;
        check(tune_o == '0, "R1 load cycle word", 64'(tune_o), 64'd0);
    endtask

    task automatic t_zero_frac;
        run_period({48'h0000_1234_5678, 8'h00}, 1'b1, -1, '0, "R3 zero fraction");
    endtask

    task automatic t_fractions;
        run_period({48'h0000_0000_0100, 8'h01}, 1'b1, -1, '0, "R2 fraction one");
        run_period({48'h0000_00AB_CDEF, 8'h5A}, 1'b1, -1, '0, "R2 fraction mid");
        run_period({48'h0000_0000_0007, 8'hFF}, 1'b1, -1, '0, "R2 fraction max");
    endtask

    task automatic t_wrap;
        run_period({ALL1, 8'h40}, 1'b1, -1, '0, "R5 all-ones base wrap");
    endtask

    task automatic t_midchange;
        logic [REQ_W-1:0] a, nb;
        a  = {48'h0000_0000_0222, 8'h10};
        nb = {48'h0000_0000_0333, 8'hC0};
        run_period(a, 1'b1, P / 2, nb, "R6 old setting held mid-period");
        run_period(nb, 1'b0, -1, '0, "R6 new setting after boundary");
    endtask

    task automatic t_overflow;
        run_period({48'h8000_0000_0000, 8'h80}, 1'b1, -1, '0, "R7 large base");
        check(carries_seen > 0, "R8 carry observed", 64'(carries_seen), 64'd1);
        check(sq_toggles > 0, "R8 square toggles", 64'(sq_toggles), 64'd1);
    endtask

    initial begin
        t_reset();
        t_zero_frac();
        t_fractions();
        t_wrap();
        t_midchange();
        t_overflow();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule